// File: doc/BRIEF.md
# Network Controller Register File and Interrupt Aggregator

This block is the host-visible control and status register file of a descriptor-driven network controller. The host reaches it through a simple single-cycle access port. A 4-bit register index is taken from address bits 6:3. The block holds the bus configuration word, the receive and transmit descriptor base addresses, the operating-mode word and the interrupt enable mask. It exports the fields that the DMA engines need: the descriptor skip length, the two base addresses with a load strobe for each current pointer, and single-cycle poll-demand pulses.

The DMA engines report four event pulses: transmit done, transmit buffer unavailable, receive done and receive buffer unavailable. Each pulse sets a sticky bit in the status word. The host clears these bits by writing ones. The block recomputes a normal and an abnormal summary bit each time the status or the mask changes, and drives a level interrupt from them. A status read also shows fixed process-state codes for a running receiver and a running transmitter. A fixed index reports a healthy clock-synthesiser self-test.

Top module: `nic_csr_top`

## Requirements
- R1: The register index is `acc_addr[6:3]`. Address bits 2:0 and 7 do not change which register a read or a write reaches.
- R2: Reads return 0 for index 1, index 2 and every unimplemented index (8–11 and 13–15). Index 12 reads as 0x0000_0030 (bits 4 and 5 set). Reads return 0 whenever `acc_en` is low or `acc_we` is high.
- R3: A write to index 0 stores the data with bit 0 (software reset) forced to 0. `skip_len_o` always equals bits 6:2 of the stored word.
- R4: A write to index 3 (receive) or index 4 (transmit) stores the base. The base appears on `rx_base_o` or `tx_base_o` and reads back. The matching `rx_ptr_ld_o` or `tx_ptr_ld_o` is high for exactly the one cycle after the write edge.
- R5: `tx_poll_o` is high for the one cycle after the write edge of a write to index 1, or of a write to index 6 with bit 13 set. `rx_poll_o` does the same for writes to index 2. Writes to index 6 with bit 13 clear give no pulse.
- R6: The event inputs set status bits and the bits stay set until cleared: `ev_tx_done` sets bit 0, `ev_tx_nobuf` sets bit 2, `ev_rx_done` sets bit 6 and `ev_rx_nobuf` sets bit 7. The status word is at index 5.
- R7: A write to index 5 clears each event bit written as 1. An event pulse in the same cycle as a clear of the same bit leaves that bit set.
- R8: Status bit 16 (normal summary) is 1 exactly when any of bits 0, 2 and 6 is set in both the status and the mask (index 7). Status bit 15 (abnormal summary) is 1 exactly when bit 7 is set in both. Both bits follow every change of status or mask.
- R9: `irq_o` is 1 exactly when (summary bit 16 and mask bit 16) or (summary bit 15 and mask bit 15). It changes at the same edge as the status word.
- R10: A status read ORs in 3 at bits 19:17 when operating-mode bit 1 (receive start) is set. It ORs in 6 at bits 22:20 when operating-mode bit 13 (transmit start) is set.
- R11: After reset all registers read 0 except index 12. `irq_o` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en | input | 1 | Access enable |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; index in bits 6:3 |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data |
| ev_tx_done | input | 1 | Transmit done event pulse |
| ev_tx_nobuf | input | 1 | Transmit buffer unavailable pulse |
| ev_rx_done | input | 1 | Receive done event pulse |
| ev_rx_nobuf | input | 1 | Receive buffer unavailable pulse |
| irq_o | output | 1 | Level interrupt |
| tx_poll_o | output | 1 | Transmit poll-demand pulse |
| rx_poll_o | output | 1 | Receive poll-demand pulse |
| skip_len_o | output | 5 | Descriptor skip length |
| rx_base_o | output | DATA_W | Receive descriptor base |
| tx_base_o | output | DATA_W | Transmit descriptor base |
| rx_ptr_ld_o | output | 1 | Load receive current pointer from base |
| tx_ptr_ld_o | output | 1 | Load transmit current pointer from base |

## Verification
The assertions assume that reset is applied before the first access. They also assume that an access and its data are stable across the clock edge that samples them, so that a write seen at one edge lines up with its effect one cycle later. The bench keeps to these assumptions: it changes access and event inputs only at falling edges and holds each for one full cycle. It sweeps every index with several patterns in the unused address bits, and every combination of the four events against every combination of the six mask bits. Each combination starts from a cleared status word, so no earlier state leaks into the expected value.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int IDX_W   = 4;
  localparam int IDX_LSB = 3;

  localparam logic [IDX_W-1:0] IX_BUSCFG = 4'd0;
  localparam logic [IDX_W-1:0] IX_TXPOLL = 4'd1;
  localparam logic [IDX_W-1:0] IX_RXPOLL = 4'd2;
  localparam logic [IDX_W-1:0] IX_RXBASE = 4'd3;
  localparam logic [IDX_W-1:0] IX_TXBASE = 4'd4;
  localparam logic [IDX_W-1:0] IX_STATUS = 4'd5;
  localparam logic [IDX_W-1:0] IX_OPMODE = 4'd6;
  localparam logic [IDX_W-1:0] IX_IMASK  = 4'd7;
  localparam logic [IDX_W-1:0] IX_SYNTH  = 4'd12;

  // status / mask bit positions
  localparam int SB_TXDONE  = 0;
  localparam int SB_TXNOBUF = 2;
  localparam int SB_RXDONE  = 6;
  localparam int SB_RXNOBUF = 7;
  localparam int SB_ABN     = 15;
  localparam int SB_NRM     = 16;

  // operating-mode and bus configuration fields
  localparam int OP_RXRUN   = 1;
  localparam int OP_TXRUN   = 13;
  localparam int BC_SWRST   = 0;
  localparam int BC_SKIP_LSB = 2;
  localparam int BC_SKIP_W   = 5;

  // synthetic process-state fields on status reads
  localparam int          RXST_LSB = 17;
  localparam logic [2:0]  RXST_RUN = 3'd3;
  localparam int          TXST_LSB = 20;
  localparam logic [2:0]  TXST_RUN = 3'd6;
  localparam int          SYN_DONE = 4;
  localparam int          SYN_PASS = 5;

  localparam int NEV = 4;  // event vector order: [3]=txdone [2]=txnobuf [1]=rxdone [0]=rxnobuf

  typedef struct packed {
    logic buscfg;
    logic txpoll;
    logic rxpoll;
    logic rxbase;
    logic txbase;
    logic status;
    logic opmode;
    logic imask;
  } wsel_t;
endpackage

// File: rtl/nic_csr_rst_sync.sv
module nic_csr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/nic_csr_decode.sv
module nic_csr_decode
  import nic_csr_pkg::*;
(
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  output wsel_t            wsel
);
  logic wr;

  always_comb begin
    wr          = en & we;
    wsel.buscfg = wr & (idx == IX_BUSCFG);
    wsel.txpoll = wr & (idx == IX_TXPOLL);
    wsel.rxpoll = wr & (idx == IX_RXPOLL);
    wsel.rxbase = wr & (idx == IX_RXBASE);
    wsel.txbase = wr & (idx == IX_TXBASE);
    wsel.status = wr & (idx == IX_STATUS);
    wsel.opmode = wr & (idx == IX_OPMODE);
    wsel.imask  = wr & (idx == IX_IMASK);
  end
endmodule

// File: rtl/nic_csr_cfg.sv
module nic_csr_cfg
  import nic_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wsel_t             wsel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] bc_q,
  output logic [DATA_W-1:0] rxb_q,
  output logic [DATA_W-1:0] txb_q,
  output logic [DATA_W-1:0] op_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] mask_d,
  output logic              tx_poll_q,
  output logic              rx_poll_q,
  output logic              rx_ld_q,
  output logic              tx_ld_q
);
  logic [DATA_W-1:0] bc_d, rxb_d, txb_d, op_d;
  logic              tx_poll_d, rx_poll_d, rx_ld_d, tx_ld_d;

  // next state
  always_comb begin
    bc_d            = wdata;
    bc_d[BC_SWRST]  = 1'b0;        // software reset never sticks
    rxb_d           = wdata;
    txb_d           = wdata;
    op_d            = wdata;
    mask_d          = wsel.imask ? wdata : mask_q;
    tx_poll_d       = wsel.txpoll | (wsel.opmode & wdata[OP_TXRUN]);
    rx_poll_d       = wsel.rxpoll;
    rx_ld_d         = wsel.rxbase;
    tx_ld_d         = wsel.txbase;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q      <= '0;
      rxb_q     <= '0;
      txb_q     <= '0;
      op_q      <= '0;
      mask_q    <= '0;
      tx_poll_q <= 1'b0;
      rx_poll_q <= 1'b0;
      rx_ld_q   <= 1'b0;
      tx_ld_q   <= 1'b0;
    end else begin
      if (wsel.buscfg) bc_q   <= bc_d;
      if (wsel.rxbase) rxb_q  <= rxb_d;
      if (wsel.txbase) txb_q  <= txb_d;
      if (wsel.opmode) op_q   <= op_d;
      if (wsel.imask)  mask_q <= mask_d;
      tx_poll_q <= tx_poll_d;
      rx_poll_q <= rx_poll_d;
      rx_ld_q   <= rx_ld_d;
      tx_ld_q   <= tx_ld_d;
    end
  end
endmodule

// File: rtl/nic_csr_irq.sv
module nic_csr_irq
  import nic_csr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev_in,      // [3]=txdone [2]=txnobuf [1]=rxdone [0]=rxnobuf
  input  logic           clr_en,
  input  logic [NEV-1:0] clr_bits,
  input  logic           mask_we,
  input  logic [NEV-1:0] mask_ev,
  input  logic           mask_nrm,
  input  logic           mask_abn,
  output logic [NEV-1:0] ev_q,
  output logic           nrm_q,
  output logic           abn_q,
  output logic           irq_q
);
  logic [NEV-1:0] ev_d;
  logic           nrm_d, abn_d, irq_d, upd;

  always_comb begin
    upd = (|ev_in) | clr_en | mask_we;
    for (int i = 0; i < NEV; i++) begin
      // a new event beats a clear on the same bit
      ev_d[i] = (ev_q[i] & ~(clr_en & clr_bits[i])) | ev_in[i];
    end
    nrm_d = |(ev_d[3:1] & mask_ev[3:1]);
    abn_d = ev_d[0] & mask_ev[0];
    irq_d = (nrm_d & mask_nrm) | (abn_d & mask_abn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= '0;
      nrm_q <= 1'b0;
      abn_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (upd) begin
      ev_q  <= ev_d;
      nrm_q <= nrm_d;
      abn_q <= abn_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/nic_csr_rdmux.sv
module nic_csr_rdmux
  import nic_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] bc_q,
  input  logic [DATA_W-1:0] rxb_q,
  input  logic [DATA_W-1:0] txb_q,
  input  logic [DATA_W-1:0] sts_word,
  input  logic [DATA_W-1:0] op_q,
  input  logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sts_rd, syn_rd;

  always_comb begin
    sts_rd = sts_word;
    if (op_q[OP_RXRUN]) sts_rd[RXST_LSB +: 3] = sts_rd[RXST_LSB +: 3] | RXST_RUN;
    if (op_q[OP_TXRUN]) sts_rd[TXST_LSB +: 3] = sts_rd[TXST_LSB +: 3] | TXST_RUN;
    syn_rd           = '0;
    syn_rd[SYN_DONE] = 1'b1;
    syn_rd[SYN_PASS] = 1'b1;

    rd_data = '0;
    if (rd_en) begin
      case (idx)
        IX_BUSCFG: rd_data = bc_q;
        IX_RXBASE: rd_data = rxb_q;
        IX_TXBASE: rd_data = txb_q;
        IX_STATUS: rd_data = sts_rd;
        IX_OPMODE: rd_data = op_q;
        IX_IMASK:  rd_data = mask_q;
        IX_SYNTH:  rd_data = syn_rd;
        default:   rd_data = '0;   // poll-demand and unimplemented
      endcase
    end
  end
endmodule

// File: rtl/nic_csr_top.sv
module nic_csr_top
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_tx_done,
  input  logic              ev_tx_nobuf,
  input  logic              ev_rx_done,
  input  logic              ev_rx_nobuf,
  output logic              irq_o,
  output logic              tx_poll_o,
  output logic              rx_poll_o,
  output logic [4:0]        skip_len_o,
  output logic [DATA_W-1:0] rx_base_o,
  output logic [DATA_W-1:0] tx_base_o,
  output logic              rx_ptr_ld_o,
  output logic              tx_ptr_ld_o
);
  logic              rst_n_s;
  logic [IDX_W-1:0]  idx;
  wsel_t             wsel;
  logic [DATA_W-1:0] bc_q, rxb_q, txb_q, op_q, mask_q, mask_d, sts_word;
  logic [NEV-1:0]    ev_in, ev_q, clr_bits, mask_ev;
  logic              nrm_q, abn_q;

  nic_csr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  assign idx = acc_addr[IDX_LSB +: IDX_W];

  nic_csr_decode u_dec (
    .en(acc_en), .we(acc_we), .idx(idx), .wsel(wsel)
  );

  nic_csr_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wsel(wsel), .wdata(acc_wdata),
    .bc_q(bc_q), .rxb_q(rxb_q), .txb_q(txb_q), .op_q(op_q),
    .mask_q(mask_q), .mask_d(mask_d),
    .tx_poll_q(tx_poll_o), .rx_poll_q(rx_poll_o),
    .rx_ld_q(rx_ptr_ld_o), .tx_ld_q(tx_ptr_ld_o)
  );

  assign ev_in    = {ev_tx_done, ev_tx_nobuf, ev_rx_done, ev_rx_nobuf};
  assign clr_bits = {acc_wdata[SB_TXDONE], acc_wdata[SB_TXNOBUF],
                     acc_wdata[SB_RXDONE], acc_wdata[SB_RXNOBUF]};
  assign mask_ev  = {mask_d[SB_TXDONE], mask_d[SB_TXNOBUF],
                     mask_d[SB_RXDONE], mask_d[SB_RXNOBUF]};

  nic_csr_irq u_irq (
    .clk(clk), .rst_n(rst_n_s), .ev_in(ev_in),
    .clr_en(wsel.status), .clr_bits(clr_bits),
    .mask_we(wsel.imask), .mask_ev(mask_ev),
    .mask_nrm(mask_d[SB_NRM]), .mask_abn(mask_d[SB_ABN]),
    .ev_q(ev_q), .nrm_q(nrm_q), .abn_q(abn_q), .irq_q(irq_o)
  );

  always_comb begin
    sts_word             = '0;
    sts_word[SB_TXDONE]  = ev_q[3];
    sts_word[SB_TXNOBUF] = ev_q[2];
    sts_word[SB_RXDONE]  = ev_q[1];
    sts_word[SB_RXNOBUF] = ev_q[0];
    sts_word[SB_ABN]     = abn_q;
    sts_word[SB_NRM]     = nrm_q;
  end

  nic_csr_rdmux #(.DATA_W(DATA_W)) u_rd (
    .rd_en(acc_en & ~acc_we), .idx(idx),
    .bc_q(bc_q), .rxb_q(rxb_q), .txb_q(txb_q), .sts_word(sts_word),
    .op_q(op_q), .mask_q(mask_q), .rd_data(rd_data)
  );

  assign skip_len_o = bc_q[BC_SKIP_LSB +: BC_SKIP_W];
  assign rx_base_o  = rxb_q;
  assign tx_base_o  = txb_q;
endmodule

// File: rtl/nic_csr_chk.sv
module nic_csr_chk
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              acc_en,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              ev_tx_done,
  input logic              ev_rx_nobuf,
  input logic [DATA_W-1:0] sts_word,
  input logic [DATA_W-1:0] mask_q,
  input logic              irq_o,
  input logic              tx_poll_o,
  input logic              rx_poll_o,
  input logic [4:0]        skip_len_o
);
  logic [IDX_W-1:0] cidx;
  logic             cwr;
  assign cidx = acc_addr[IDX_LSB +: IDX_W];
  assign cwr  = acc_en && acc_we;

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o == ((sts_word[SB_NRM] && mask_q[SB_NRM]) || (sts_word[SB_ABN] && mask_q[SB_ABN])));

  assert_abn_summary_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    sts_word[SB_ABN] == (sts_word[SB_RXNOBUF] && mask_q[SB_RXNOBUF]));

  assert_nrm_summary_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    sts_word[SB_NRM] == ((sts_word[SB_TXDONE] && mask_q[SB_TXDONE]) ||
                         (sts_word[SB_TXNOBUF] && mask_q[SB_TXNOBUF]) ||
                         (sts_word[SB_RXDONE] && mask_q[SB_RXDONE])));

  assert_txpoll_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cwr && cidx == IX_TXPOLL) |=> tx_poll_o);

  assert_rxpoll_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cwr && cidx == IX_RXPOLL) |=> rx_poll_o);

  assert_sticky_set_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    ev_rx_nobuf |=> sts_word[SB_RXNOBUF]);

  assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cwr && cidx == IX_STATUS && acc_wdata[SB_TXDONE] && !ev_tx_done) |=> !sts_word[SB_TXDONE]);

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    ev_tx_done |=> sts_word[SB_TXDONE]);

  assert_skip_len_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cwr && cidx == IX_BUSCFG) |=> (skip_len_o == $past(acc_wdata[BC_SKIP_LSB +: BC_SKIP_W])));
endmodule

bind nic_csr_top nic_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .acc_en(acc_en), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata),
  .ev_tx_done(ev_tx_done), .ev_rx_nobuf(ev_rx_nobuf),
  .sts_word(sts_word), .mask_q(mask_q), .irq_o(irq_o),
  .tx_poll_o(tx_poll_o), .rx_poll_o(rx_poll_o), .skip_len_o(skip_len_o)
);

// File: tb/tb_nic_csr_top.sv
`timescale 1ns/1ps
module tb_nic_csr_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_en, acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata, rd_data, rx_base_o, tx_base_o;
  logic ev_tx_done, ev_tx_nobuf, ev_rx_done, ev_rx_nobuf;
  logic irq_o, tx_poll_o, rx_poll_o, rx_ptr_ld_o, tx_ptr_ld_o;
  logic [4:0] skip_len_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic p_tx, p_rx, p_rxld, p_txld;

  always #2.5 clk = ~clk;

  nic_csr_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .ev_tx_done(ev_tx_done), .ev_tx_nobuf(ev_tx_nobuf),
    .ev_rx_done(ev_rx_done), .ev_rx_nobuf(ev_rx_nobuf),
    .irq_o(irq_o), .tx_poll_o(tx_poll_o), .rx_poll_o(rx_poll_o),
    .skip_len_o(skip_len_o), .rx_base_o(rx_base_o), .tx_base_o(tx_base_o),
    .rx_ptr_ld_o(rx_ptr_ld_o), .tx_ptr_ld_o(tx_ptr_ld_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkaddr(input int idx, input int junk);
    return {junk[3], idx[3:0], junk[2:0]};
  endfunction

  task automatic wr(input int idx, input logic [31:0] d, input int junk);
    acc_addr = mkaddr(idx, junk); acc_wdata = d; acc_en = 1; acc_we = 1;
    @(posedge clk); @(negedge clk);
    p_tx = tx_poll_o; p_rx = rx_poll_o; p_rxld = rx_ptr_ld_o; p_txld = tx_ptr_ld_o;
    acc_en = 0; acc_we = 0;
  endtask

  task automatic rd(input int idx, input int junk, output logic [31:0] v);
    acc_addr = mkaddr(idx, junk); acc_en = 1; acc_we = 0;
    #1; v = rd_data; acc_en = 0;
  endtask

  task automatic pulse_ev(input logic [3:0] e);
    {ev_rx_nobuf, ev_rx_done, ev_tx_nobuf, ev_tx_done} = e;
    @(posedge clk); @(negedge clk);
    {ev_rx_nobuf, ev_rx_done, ev_tx_nobuf, ev_tx_done} = '0;
  endtask

  // e bit0=txdone bit1=txnobuf bit2=rxdone bit3=rxnobuf
  function automatic logic [31:0] ev_bits(input logic [3:0] e);
    return (e[0] ? 32'h1 : 0) | (e[1] ? 32'h4 : 0) | (e[2] ? 32'h40 : 0) | (e[3] ? 32'h80 : 0);
  endfunction

  function automatic logic [31:0] exp_sts(input logic [31:0] st, input logic [31:0] m);
    logic [31:0] r = st;
    if ((st & m & 32'h45) != 0) r |= 32'h1_0000;
    if ((st & m & 32'h80) != 0) r |= 32'h0_8000;
    return r;
  endfunction

  function automatic logic exp_irq(input logic [31:0] st, input logic [31:0] m);
    logic [31:0] s = exp_sts(st, m);
    return (s[16] && m[16]) || (s[15] && m[15]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp, m;
    rst_n = 0; acc_en = 0; acc_we = 0; acc_addr = '0; acc_wdata = '0;
    {ev_rx_nobuf, ev_rx_done, ev_tx_nobuf, ev_tx_done} = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 irq", {31'd0, irq_o}, 0);
    chk("R11 strobes", {28'd0, tx_poll_o, rx_poll_o, rx_ptr_ld_o, tx_ptr_ld_o}, 0);
    chk("R11 skip", {27'd0, skip_len_o}, 0);
    // R1/R2/R11: sweep every index with junk address bits
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        rd(i, j, v);
        chk("R1 R2 R11 reset read", v, (i == 12) ? 32'h30 : 32'h0);
      end

    // R3 bus config
    wr(0, 32'hA5A5_5A5B, 5);
    rd(0, 9, v);  chk("R3 swrst self-clear", v, 32'hA5A5_5A5A);
    chk("R3 skip len", {27'd0, skip_len_o}, {27'd0, 5'h16});
    // R4 bases
    wr(3, 32'h1000_0040, 3);
    chk("R4 rx load strobe", {31'd0, p_rxld}, 1);
    chk("R4 tx load quiet", {31'd0, p_txld}, 0);
    chk("R4 rx base out", rx_base_o, 32'h1000_0040);
    @(negedge clk); chk("R4 rx strobe single", {31'd0, rx_ptr_ld_o}, 0);
    wr(4, 32'h2000_0080, 14);
    chk("R4 tx load strobe", {31'd0, p_txld}, 1);
    chk("R4 tx base out", tx_base_o, 32'h2000_0080);
    @(negedge clk); chk("R4 tx strobe single", {31'd0, tx_ptr_ld_o}, 0);
    // R5 poll pulses
    wr(1, 32'h0, 7);
    chk("R5 txpoll idx1", {31'd0, p_tx}, 1);
    @(negedge clk); chk("R5 txpoll single", {31'd0, tx_poll_o}, 0);
    wr(2, 32'h0, 8);
    chk("R5 rxpoll idx2", {31'd0, p_rx}, 1);
    chk("R5 no txpoll on idx2", {31'd0, p_tx}, 0);
    @(negedge clk); chk("R5 rxpoll single", {31'd0, rx_poll_o}, 0);
    wr(6, 32'h0000_0002, 0);
    chk("R5 opmode no start", {31'd0, p_tx}, 0);
    rd(5, 0, v); chk("R10 rx run state", v, 32'h0006_0000);
    wr(6, 32'h0000_2002, 15);
    chk("R5 opmode start tx", {31'd0, p_tx}, 1);
    rd(5, 2, v); chk("R10 rx+tx run state", v, 32'h0066_0000);
    wr(6, 32'h0000_2000, 1);
    rd(5, 3, v); chk("R10 tx run state", v, 32'h0060_0000);
    wr(7, 32'h0001_80C5, 6);
    // R1 R2 full readback sweep with model
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        case (i)
          0: exp = 32'hA5A5_5A5A;
          3: exp = 32'h1000_0040;
          4: exp = 32'h2000_0080;
          5: exp = 32'h0060_0000;
          6: exp = 32'h0000_2000;
          7: exp = 32'h0001_80C5;
          12: exp = 32'h30;
          default: exp = 0;
        endcase
        rd(i, j, v);
        chk("R1 R2 readback sweep", v, exp);
      end
    // R2 write cycles never drive read data
    acc_addr = mkaddr(0, 0); acc_en = 1; acc_we = 1; acc_wdata = 32'hA5A5_5A5A; #1;
    chk("R2 no data on write", rd_data, 0);
    @(posedge clk); @(negedge clk); acc_en = 0; acc_we = 0;

    wr(6, 32'h0, 0);
    // R6 R8 R9 exhaustive events x mask
    for (int mi = 0; mi < 64; mi++) begin
      m = (mi[0] ? 32'h1 : 0) | (mi[1] ? 32'h4 : 0) | (mi[2] ? 32'h40 : 0) |
          (mi[3] ? 32'h80 : 0) | (mi[4] ? 32'h8000 : 0) | (mi[5] ? 32'h1_0000 : 0);
      wr(7, m, mi % 16);
      for (int e = 0; e < 16; e++) begin
        wr(5, 32'hFFFF_FFFF, e);
        chk("R7 clear-all irq", {31'd0, irq_o}, 0);
        pulse_ev(e[3:0]);
        @(negedge clk);  // one idle cycle: bits must hold (sticky)
        rd(5, e, v);
        chk("R6 R8 status", v, exp_sts(ev_bits(e[3:0]), m));
        chk("R9 irq", {31'd0, irq_o}, {31'd0, exp_irq(ev_bits(e[3:0]), m)});
      end
    end

    // R7 partial clear
    wr(7, 32'h0001_80C5, 0);
    wr(5, 32'hFFFF_FFFF, 0);
    pulse_ev(4'hF);
    wr(5, 32'h0000_0041, 2);
    rd(5, 0, v); chk("R7 partial clear", v, exp_sts(32'h84, 32'h0001_80C5));
    // R7 event wins over same-cycle clear
    acc_addr = mkaddr(5, 0); acc_wdata = 32'h0000_0085; acc_en = 1; acc_we = 1; ev_tx_done = 1;
    @(posedge clk); @(negedge clk);
    acc_en = 0; acc_we = 0; ev_tx_done = 0;
    rd(5, 0, v); chk("R7 event beats clear", v, exp_sts(32'h1, 32'h0001_80C5));
    chk("R9 irq after collide", {31'd0, irq_o}, 1);
    // R8/R9 mask change alone re-evaluates summary and irq
    pulse_ev(4'h8);
    wr(7, 32'h0000_8080, 0);
    rd(5, 0, v); chk("R8 mask change abn", v, exp_sts(32'h81, 32'h8080));
    chk("R9 abn irq", {31'd0, irq_o}, 1);
    wr(7, 32'h0000_0080, 0);
    chk("R9 abn disabled", {31'd0, irq_o}, 0);
    wr(7, 32'h0, 0);
    rd(5, 0, v); chk("R8 mask cleared", v, 32'h81);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule